// File: doc/BRIEF.md
# Quad-Lane Serial Flash Master Engine

This block is a serial master that moves one data word at a time to and from a serial flash or SPI device. A single 32-bit configuration word, written through a small register port, sets every aspect of the transfer. It selects the serial clock rate as a power-of-two division of the system clock and the idle level of that clock. It chooses whether chip select is generated around each word or held by software, and whether a word goes out as soon as it is offered or only on an explicit start command. It also sets the byte order at the word interface and how many data lines carry each beat.

In flash-interface mode the engine can spread a word over one, two or four data lines, in a write or a read direction. The HOLD and WP lines (IO3/IO2) can be held high by the master while fewer than four lanes are in use. In legacy mode it behaves as a plain single-bit SPI master, and every line except IO0 is left undriven. A second register address returns a busy flag. The configuration cannot be changed while a word is on the wire.

Top module: `qspi_ctl_engine`

## Requirements
- R1: After reset the configuration word reads 0x80000000 (flash-interface mode on, everything else off). In that state cs_n is 1, sclk is 0, io_oe is 0000 and busy reads 0.
- R2: With one lane, a word is shifted MSB first on IO0 using 32 sclk pulses. Each bit is sampled from IO1 on the rising sclk edge and presented on the falling edge. The received word appears on rx_word with rx_valid high for exactly one cycle after the last pulse.
- R3: The 3-bit divisor N at bits 5:3 gives an sclk period of 2^(N+1) system clocks, from 2 for N=0 to 256 for N=7.
- R4: With automatic chip select (bit 14 = 0), cs_n is 0 for exactly the cycles in which a word is being transferred and 1 otherwise.
- R5: The polarity bit (bit 1) sets the idle sclk level, high when 1. Transferred data is identical for the supported pairs {bit 2, bit 1} = 00 and 11.
- R6: With manual start (bit 15 = 1), offered data is not taken until a configuration write sets bit 16 while tx_valid is high. Bit 16 always reads back as 0.
- R7: With manual chip select (bit 14 = 1), cs_n equals bit 10 at all times, including during a transfer.
- R8: When bit 26 is 1, the bytes of the transmit word are reversed before shifting and the bytes of the received word are reversed on rx_word. When it is 0, words pass unchanged.
- R9: In flash mode the lane field at bits 12:11 selects 1 (00), 2 (01) or 4 (10/11) lanes, with IO0 carrying the lowest bit of each beat, so 32, 16 or 8 sclk pulses are used. In multi-lane modes bit 13 = 0 drives the lanes and gives no rx_valid, while bit 13 = 1 leaves them undriven and receives from them.
- R10: When bit 19 is 1 in flash mode with one or two lanes, IO3 and IO2 are driven high at all times.
- R11: In legacy mode (bit 31 = 0), io_oe[3:1] stays 0 and transfers use one lane whatever the lane field says.
- R12: Only bits 31, 26, 19, 15:10 and 5:0 store written values. All other bits read as 0.
- R13: With the master-enable bit (bit 0) at 0, tx_ready stays 0 and no transfer starts.
- R14: Configuration writes that arrive during a transfer are discarded. Register address 1 reads busy in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the configuration word, 1 selects status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_word | input | 32 | Word to transmit |
| tx_valid | input | 1 | tx_word is offered |
| tx_ready | output | 1 | The offered word is taken at this clock edge when tx_valid is high |
| rx_word | output | 32 | Received word |
| rx_valid | output | 1 | One-cycle strobe marking rx_word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_oe | output | 4 | Output enable per data line |
| io_out | output | 4 | Output value per data line |
| io_in | input | 4 | Input value per data line |

## Verification
A slave model in the bench returns a known word on the input lines and collects what the master drives at each rising sclk. Transfers are run at one, two and four lanes and in legacy mode, so that beat counts and lane-to-bit ordering can be told apart. The transmit and return words use distinct byte patterns, so that a byte reversal or a bit-order error shows up as a different value. Divisors 0, 3 and 7, and both clock polarities, separate the period and idle-level logic from the data path. Tests with start, chip-select and enable control, and a write aimed at a running transfer, confirm that nothing moves or changes when it should not.

// File: rtl/qspi_eng_pkg.sv
// Shared constants and types for the serial flash master engine.
// Assumes a 32-bit configuration word with the bit layout given below.
package qspi_eng_pkg;

    localparam int          CFG_W       = 32;
    localparam logic [31:0] CFG_RESET   = 32'h8000_0000;
    localparam logic [31:0] CFG_WR_MASK = 32'h8408_FC3F;

    localparam int B_FLASH  = 31;
    localparam int B_ENDIAN = 26;
    localparam int B_HOLD   = 19;
    localparam int B_GO     = 16;
    localparam int B_MSTART = 15;
    localparam int B_MCS    = 14;
    localparam int B_RDDIR  = 13;
    localparam int B_LN_HI  = 12;
    localparam int B_LN_LO  = 11;
    localparam int B_CSLVL  = 10;
    localparam int B_DIV_HI = 5;
    localparam int B_DIV_LO = 3;
    localparam int B_CPOL   = 1;
    localparam int B_MEN    = 0;

    typedef enum logic [1:0] {
        LANES_1 = 2'd0,
        LANES_2 = 2'd1,
        LANES_4 = 2'd2
    } lane_e;

    typedef struct packed {
        logic       flash;
        logic       big_end;
        logic       hold_drv;
        logic       man_start;
        logic       man_cs;
        logic       rd_dir;
        logic [1:0] lanes;
        logic       cs_level;
        logic [2:0] div;
        logic       cpol;
        logic       master_en;
    } cfg_t;

endpackage

// File: rtl/qspi_cfg_regs.sv
// Configuration and status registers.
// Holds the masked configuration word and decodes its fields. It turns a
// write of the start bit into a one-cycle pulse. Writes are discarded
// while a transfer is running. Assumes reg_addr 0 = config, 1 = status.
module qspi_cfg_regs
    import qspi_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              busy,
    output logic [CFG_W-1:0]  rdata,
    output cfg_t              cfg,
    output logic              start_pulse
);

    logic [CFG_W-1:0] cfg_q;
    logic             start_q;
    logic             wr_ok;

    // write accepted only to the config address while idle
    assign wr_ok = wr_en && !addr && !busy;

    // register storage and start pulse generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= CFG_RESET;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (wr_ok) begin
                cfg_q   <= wdata & CFG_WR_MASK;
                start_q <= wdata[B_GO];
            end
        end
    end

    // field decode of the stored word
    always_comb begin
        cfg.flash     = cfg_q[B_FLASH];
        cfg.big_end   = cfg_q[B_ENDIAN];
        cfg.hold_drv  = cfg_q[B_HOLD];
        cfg.man_start = cfg_q[B_MSTART];
        cfg.man_cs    = cfg_q[B_MCS];
        cfg.rd_dir    = cfg_q[B_RDDIR];
        cfg.lanes     = cfg_q[B_LN_HI:B_LN_LO];
        cfg.cs_level  = cfg_q[B_CSLVL];
        cfg.div       = cfg_q[B_DIV_HI:B_DIV_LO];
        cfg.cpol      = cfg_q[B_CPOL];
        cfg.master_en = cfg_q[B_MEN];
    end

    // read multiplexer: config word or busy status
    always_comb begin
        if (!addr) rdata = cfg_q;
        else       rdata = {{(CFG_W-1){1'b0}}, busy};
    end

    assign start_pulse = start_q;

endmodule

// File: rtl/qspi_sclk_div.sv
// Half-period tick generator for the serial clock.
// While run is high it emits one tick every 2^div system clocks. The
// counter is held at zero while run is low, so the first half period
// starts on the cycle the transfer begins.
module qspi_sclk_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    // terminal count 2^div - 1
    assign lim  = {CNT_W{1'b1}} >> (CNT_W - int'(div));
    assign tick = run && (cnt_q == lim);

    // half-period counter
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || tick)   cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/qspi_shift_core.sv
// Word shifter for 1, 2 or 4 lanes.
// A word is loaded on go. Each tick toggles the internal phase: the
// phase 0->1 tick samples input lanes (rising sclk) and the phase 1->0
// tick advances the output lanes (falling sclk). After the last beat
// busy drops and the received word is captured.
module qspi_shift_core
    import qspi_eng_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick,
    input  lane_e             lanes,
    input  logic              recv_en,
    input  logic [WORD_W-1:0] tx_data,
    input  logic [3:0]        io_in,
    output logic              busy,
    output logic              phase,
    output logic [3:0]        tx_top,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_pulse
);

    localparam int BEAT_W = $clog2(WORD_W);

    logic              busy_q, ph_q;
    logic [BEAT_W-1:0] beat_q, last_beat;
    logic [WORD_W-1:0] sh_q, sh_nx, rx_q, rx_nx;

    // beat count and next shift values per lane width
    always_comb begin
        case (lanes)
            LANES_1: begin
                last_beat = BEAT_W'(WORD_W - 1);
                sh_nx     = {sh_q[WORD_W-2:0], 1'b0};
                rx_nx     = {rx_q[WORD_W-2:0], io_in[1]};
            end
            LANES_2: begin
                last_beat = BEAT_W'(WORD_W/2 - 1);
                sh_nx     = {sh_q[WORD_W-3:0], 2'b00};
                rx_nx     = {rx_q[WORD_W-3:0], io_in[1:0]};
            end
            default: begin
                last_beat = BEAT_W'(WORD_W/4 - 1);
                sh_nx     = {sh_q[WORD_W-5:0], 4'b0000};
                rx_nx     = {rx_q[WORD_W-5:0], io_in};
            end
        endcase
    end

    // transfer sequencing, shifting and capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            ph_q     <= 1'b0;
            beat_q   <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            rx_data  <= '0;
            rx_pulse <= 1'b0;
        end else begin
            rx_pulse <= 1'b0;
            if (go && !busy_q) begin
                busy_q <= 1'b1;
                ph_q   <= 1'b0;
                beat_q <= '0;
                sh_q   <= tx_data;
            end else if (busy_q && tick) begin
                if (!ph_q) begin
                    ph_q <= 1'b1;
                    rx_q <= rx_nx;
                end else begin
                    ph_q <= 1'b0;
                    if (beat_q == last_beat) begin
                        busy_q   <= 1'b0;
                        rx_data  <= rx_q;
                        rx_pulse <= recv_en;
                    end else begin
                        beat_q <= beat_q + 1'b1;
                        sh_q   <= sh_nx;
                    end
                end
            end
        end
    end

    assign busy   = busy_q;
    assign phase  = ph_q;
    assign tx_top = sh_q[WORD_W-1 -: 4];

endmodule

// File: rtl/qspi_ctl_engine.sv
// Serial flash master engine top level.
// Joins the register block, the clock divider and the shifter. Decides
// when a word starts, generates chip select and sclk, reverses byte order
// when asked, and maps the shifter lanes onto the four data pins.
// Assumes WORD_W is a multiple of 8 and at least 8.
module qspi_ctl_engine
    import qspi_eng_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DIV_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_addr,
    input  logic [CFG_W-1:0]  reg_wdata,
    output logic [CFG_W-1:0]  reg_rdata,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              sclk,
    output logic              cs_n,
    output logic [3:0]        io_oe,
    output logic [3:0]        io_out,
    input  logic [3:0]        io_in
);

    localparam int NBYTES = WORD_W / 8;

    cfg_t              cfg;
    logic              start_pulse, busy, phase, tick, go, recv_en;
    lane_e             eff_lanes;
    logic [3:0]        tx_top;
    logic [WORD_W-1:0] tx_sw, tx_load, rx_raw, rx_sw;

    qspi_cfg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .busy        (busy),
        .rdata       (reg_rdata),
        .cfg         (cfg),
        .start_pulse (start_pulse)
    );

    qspi_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (cfg.div[DIV_W-1:0]),
        .tick  (tick)
    );

    // byte reversal network for both word directions
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign tx_sw[b*8 +: 8] = tx_word[(NBYTES-1-b)*8 +: 8];
        assign rx_sw[b*8 +: 8] = rx_raw[(NBYTES-1-b)*8 +: 8];
    end

    assign tx_load = cfg.big_end ? tx_sw : tx_word;
    assign rx_word = cfg.big_end ? rx_sw : rx_raw;

    // effective lane count: legacy mode forces a single lane
    always_comb begin
        if (!cfg.flash)            eff_lanes = LANES_1;
        else if (cfg.lanes == 2'd0) eff_lanes = LANES_1;
        else if (cfg.lanes == 2'd1) eff_lanes = LANES_2;
        else                        eff_lanes = LANES_4;
    end

    assign recv_en  = (eff_lanes == LANES_1) || cfg.rd_dir;
    assign tx_ready = !busy && cfg.master_en && (!cfg.man_start || start_pulse);
    assign go       = tx_valid && tx_ready;

    qspi_shift_core #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .tick     (tick),
        .lanes    (eff_lanes),
        .recv_en  (recv_en),
        .tx_data  (tx_load),
        .io_in    (io_in),
        .busy     (busy),
        .phase    (phase),
        .tx_top   (tx_top),
        .rx_data  (rx_raw),
        .rx_pulse (rx_valid)
    );

    // serial clock and chip select
    assign sclk = busy ? phase : cfg.cpol;
    assign cs_n = cfg.man_cs ? cfg.cs_level : !busy;

    // data pin direction and value per lane mode
    always_comb begin
        io_oe  = 4'b0000;
        io_out = 4'b0000;
        case (eff_lanes)
            LANES_1: begin
                io_oe[0]  = busy;
                io_out[0] = busy & tx_top[3];
            end
            LANES_2: begin
                io_oe[1:0]  = {2{busy & !cfg.rd_dir}};
                io_out[1:0] = busy ? tx_top[3:2] : 2'b00;
            end
            default: begin
                io_oe  = {4{busy & !cfg.rd_dir}};
                io_out = busy ? tx_top : 4'b0000;
            end
        endcase
        if (eff_lanes != LANES_4) begin
            io_oe[3:2]  = {2{cfg.flash & cfg.hold_drv}};
            io_out[3:2] = {2{cfg.flash & cfg.hold_drv}};
        end
    end

endmodule

// File: rtl/qspi_ctl_engine_chk.sv
// Property checker for the serial flash master engine, bound to the top.
// Observes the decoded configuration, busy and the pins.
module qspi_ctl_engine_chk
    import qspi_eng_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input cfg_t        cfg,
    input logic        busy,
    input logic        sclk,
    input logic        cs_n,
    input logic [3:0]  io_oe,
    input logic [3:0]  io_out,
    input logic        rx_valid,
    input logic        tx_ready,
    input logic        reg_addr,
    input logic [31:0] reg_rdata
);

    a_r2_rxv_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(busy));

    a_r5_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cfg.cpol));

    a_r6_go_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> !reg_rdata[16]);

    a_r7_manual_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.man_cs |-> (cs_n == cfg.cs_level));

    a_r9_quad_read_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg.flash && cfg.lanes[1] && cfg.rd_dir) |-> (io_oe == 4'b0000));

    a_r10_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.flash && cfg.hold_drv && !cfg.lanes[1]) |-> (io_oe[3:2] == 2'b11 && io_out[3:2] == 2'b11));

    a_r11_legacy_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.flash |-> (io_oe[3:1] == 3'b000));

    a_r13_disabled_no_go: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.master_en |-> !tx_ready);

    a_r14_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg));

endmodule

bind qspi_ctl_engine qspi_ctl_engine_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .busy      (busy),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .io_oe     (io_oe),
    .io_out    (io_out),
    .rx_valid  (rx_valid),
    .tx_ready  (tx_ready),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/qspi_ctl_engine_tb_top.sv
`timescale 1ns/1ps
module qspi_ctl_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] tx_word = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] rx_word;
    logic        rx_valid;
    logic        sclk, cs_n;
    logic [3:0]  io_oe, io_out;
    logic [3:0]  io_in = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    // slave model and monitor state
    int          lanes_tb = 1;
    logic [31:0] mw_sh, mo, rx_cap, tmp;
    int          rises, cs_low_cnt, rxv_cnt, cyc, last_rise, period;
    logic [3:0]  oe_rise, out_rise;
    logic        prev_sclk;

    always #2.5 clk = ~clk;

    qspi_ctl_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_word(tx_word),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_word(rx_word),
        .rx_valid(rx_valid), .sclk(sclk), .cs_n(cs_n), .io_oe(io_oe),
        .io_out(io_out), .io_in(io_in)
    );

    function automatic logic [3:0] in_bits(logic [31:0] w, int l);
        if (l == 1)      return {2'b00, w[31], 1'b0};
        else if (l == 2) return {2'b00, w[31:30]};
        else             return w[31:28];
    endfunction

    // monitor and slave: sample master lanes on rising sclk, then advance
    always @(negedge clk) begin
        cyc++;
        if (!cs_n) cs_low_cnt++;
        if (rx_valid) begin rxv_cnt++; rx_cap = rx_word; end
        if (sclk && !prev_sclk) begin
            rises++;
            period    = cyc - last_rise;
            last_rise = cyc;
            oe_rise   = io_oe;
            out_rise  = io_out;
            if (lanes_tb == 1)      mo = {mo[30:0], io_out[0]};
            else if (lanes_tb == 2) mo = {mo[29:0], io_out[1:0]};
            else                    mo = {mo[27:0], io_out};
            mw_sh = mw_sh << lanes_tb;
            io_in = in_bits(mw_sh, lanes_tb);
        end
        prev_sclk = sclk;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(logic [31:0] v);
        @(negedge clk);
        reg_addr = 1'b0; reg_wdata = v; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic arm(logic [31:0] mw, int l);
        lanes_tb = l; mw_sh = mw; io_in = in_bits(mw, l);
        mo = '0; rises = 0; cs_low_cnt = 0; rxv_cnt = 0; rx_cap = '0;
        last_rise = cyc; period = 0;
    endtask

    // offer a word (caller stands at a negedge) and drop it once taken
    task automatic push_word(logic [31:0] w);
        tx_word = w; tx_valid = 1'b1;
        for (int i = 0; i < 200; i++) begin
            #1;
            if (tx_ready) begin @(negedge clk); tx_valid = 1'b0; return; end
            @(negedge clk);
        end
        tx_valid = 1'b0;
        chk("push timeout", 32'd0, 32'd1);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(1'b1, s);
            if (s[0] == 1'b0) begin @(negedge clk); @(negedge clk); return; end
            @(negedge clk);
        end
        chk("idle timeout", 32'd0, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(1'b0, v); chk("R1 cfg reset", v, 32'h8000_0000);
        rd(1'b1, v); chk("R1 busy reset", v, 32'h0);
        chk("R1 pins reset", {cs_n, sclk, io_oe}, {1'b1, 1'b0, 4'b0000});
    endtask

    task automatic t_single_lane();
        wr_cfg(32'h8000_0001);
        arm(32'h3C5A_F00D, 1);
        push_word(32'hA5C3_0F96); wait_idle();
        chk("R2 mosi word", mo, 32'hA5C3_0F96);
        chk("R2 miso word", rx_cap, 32'h3C5A_F00D);
        chk("R2 pulses", rises, 32);
        chk("R2 rx_valid once", rxv_cnt, 1);
        chk("R4 cs low cycles", cs_low_cnt, 64);
        chk("R4 cs idle", cs_n, 1'b1);
    endtask

    task automatic t_divider();
        wr_cfg(32'h8000_0019);
        arm(32'h0F0F_1234, 1);
        push_word(32'h1357_9BDF); wait_idle();
        chk("R3 period N=3", period, 16);
        chk("R3 data N=3", mo, 32'h1357_9BDF);
        chk("R4 cs low N=3", cs_low_cnt, 512);
        wr_cfg(32'h8000_0039);
        arm(32'h0, 1);
        push_word(32'h8000_0001); wait_idle();
        chk("R3 period N=7", period, 256);
        chk("R3 pulses N=7", rises, 32);
    endtask

    task automatic t_polarity();
        wr_cfg(32'h8000_0007);
        @(negedge clk);
        chk("R5 idle high", sclk, 1'b1);
        arm(32'hC001_D00D, 1);
        push_word(32'h5A5A_0FF0); wait_idle();
        chk("R5 data mode 3", mo, 32'h5A5A_0FF0);
        chk("R5 rx mode 3", rx_cap, 32'hC001_D00D);
        chk("R5 idle after", sclk, 1'b1);
    endtask

    task automatic t_manual_start();
        logic [31:0] v;
        wr_cfg(32'h8000_8001);
        arm(32'h2468_ACE0, 1);
        tx_word = 32'h7777_1111; tx_valid = 1'b1;
        repeat (20) @(negedge clk);
        chk("R6 no start pulses", rises, 0);
        chk("R6 no cs", cs_low_cnt, 0);
        wr_cfg(32'h8001_8001);
        push_word(32'h7777_1111); wait_idle();
        chk("R6 word after start", mo, 32'h7777_1111);
        rd(1'b0, v); chk("R6 go bit reads 0", v, 32'h8000_8001);
    endtask

    task automatic t_manual_cs();
        wr_cfg(32'h8000_4001);
        @(negedge clk);
        chk("R7 cs follows 0", cs_n, 1'b0);
        wr_cfg(32'h8000_4401);
        arm(32'h0, 1);
        push_word(32'h0000_00FF); wait_idle();
        chk("R7 cs held high", cs_low_cnt, 0);
        chk("R7 word sent", mo, 32'h0000_00FF);
    endtask

    task automatic t_endian();
        wr_cfg(32'h8400_0001);
        arm(32'hAABB_CCDD, 1);
        push_word(32'h1122_3344); wait_idle();
        chk("R8 tx swapped", mo, 32'h4433_2211);
        chk("R8 rx swapped", rx_cap, 32'hDDCC_BBAA);
    endtask

    task automatic t_lanes();
        wr_cfg(32'h8000_1001);
        arm(32'h0, 4);
        push_word(32'hFEDC_BA98); wait_idle();
        chk("R9 quad write data", mo, 32'hFEDC_BA98);
        chk("R9 quad pulses", rises, 8);
        chk("R9 quad oe", oe_rise, 4'hF);
        chk("R9 quad write no rx", rxv_cnt, 0);
        wr_cfg(32'h8000_3001);
        arm(32'h9182_7364, 4);
        push_word(32'h0); wait_idle();
        chk("R9 quad read data", rx_cap, 32'h9182_7364);
        chk("R9 quad read oe", oe_rise, 4'h0);
        wr_cfg(32'h8008_0801);
        arm(32'h0, 2);
        push_word(32'h6C6C_39E1); wait_idle();
        chk("R9 dual write data", mo, 32'h6C6C_39E1);
        chk("R9 dual pulses", rises, 16);
        chk("R10 hold oe in dual", oe_rise, 4'hF);
        chk("R10 hold level", out_rise[3:2], 2'b11);
        chk("R10 hold idle", io_oe, 4'b1100);
    endtask

    task automatic t_legacy();
        wr_cfg(32'h0008_1001);
        arm(32'h5566_7788, 1);
        push_word(32'h0BAD_F00D); wait_idle();
        chk("R11 legacy pulses", rises, 32);
        chk("R11 legacy oe", oe_rise, 4'b0001);
        chk("R11 legacy data", mo, 32'h0BAD_F00D);
        chk("R11 legacy rx", rx_cap, 32'h5566_7788);
        chk("R11 idle oe", io_oe, 4'b0000);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr_cfg(32'h7BF6_03C1);
        rd(1'b0, v); chk("R12 reserved zero", v, 32'h0000_0001);
        wr_cfg(32'hFFFE_FFFF);
        rd(1'b0, v); chk("R12 writable mask", v, 32'h8408_FC3F);
    endtask

    task automatic t_disabled();
        wr_cfg(32'h8000_0000);
        arm(32'h0, 1);
        tx_word = 32'h1234_5678; tx_valid = 1'b1;
        #1 chk("R13 ready low", tx_ready, 1'b0);
        repeat (30) @(negedge clk);
        tx_valid = 1'b0;
        chk("R13 no pulses", rises, 0);
        chk("R13 no cs", cs_low_cnt, 0);
    endtask

    task automatic t_busy_write();
        logic [31:0] v;
        wr_cfg(32'h8000_0019);
        arm(32'h0, 1);
        push_word(32'hCAFE_0001);
        repeat (5) @(negedge clk);
        rd(1'b1, v); chk("R14 busy status", v, 32'h1);
        wr_cfg(32'h8000_0007);
        wait_idle();
        rd(1'b0, v); chk("R14 write dropped", v, 32'h8000_0019);
        chk("R14 word intact", mo, 32'hCAFE_0001);
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        prev_sclk = 1'b0; cyc = 0; mw_sh = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_lane();
        t_divider();
        t_polarity();
        t_manual_start();
        t_manual_cs();
        t_endian();
        t_lanes();
        t_legacy();
        t_reserved();
        t_disabled();
        t_busy_write();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule